// File: doc/BRIEF.md
# Cascaded Driver Update Sequencer

This block refreshes a daisy chain of two 8-bit latched shift-register drivers from a 16-bit status word. A start strobe captures the word. The block then sends it out serially on a generated shift clock, most significant bit first. After the sixteenth rising shift edge it gives the register clock a single pulse, so that the downstream storage registers update once with the whole frame. A 1 in the word turns the matching driver output on and a 0 leaves it off.

The first frame after reset is preceded by a clear pulse on the active-low clear line. The active-low output-enable line is driven continuously by an 8-bit PWM generator, so one duty input sets the brightness of every output at once.

The start strobe and the status word form a plain control interface, not a stream. A start is taken only while `busy_o` is low. A start that arrives while busy is dropped, and nothing needs to be held for it. Every generated clock phase lasts `HALF_CYC` system-clock cycles. A check at elaboration rejects any setting that gives a phase shorter than 40 ns or a shift clock faster than 10 MHz.

Top module: `shreg_frame_driver`

## Requirements
- R1: While reset is active and directly after it, `sclk_o` and `rclk_o` are 0, `clr_no`, `oe_no` and `sdata_o` are in their off state (1, 1, 0), and `busy_o` is 0.
- R2: A start accepted while idle drives `busy_o` high one clock later. A start that arrives while busy is ignored and does not change the frame being sent.
- R3: The first frame after reset begins with `clr_no` low for exactly `HALF_CYC` cycles, with both clocks low. Later frames never drive `clr_no` low.
- R4: Each frame produces exactly 16 rising edges on `sclk_o`. The bits sampled at those edges are the word's bits 15 down to 0. In a model of two chained 8-bit stages, the far stage holds bits 15..8, with bit 15 at its output 7, and the near stage holds bits 7..0, with bit 0 at its output 0.
- R5: `sdata_o` changes only while `sclk_o` is low. Every shift-clock high phase and every low phase between two bits lasts exactly `HALF_CYC` cycles.
- R6: Each frame issues exactly one `rclk_o` pulse, `HALF_CYC` cycles high, only after the sixteenth shift edge. `sclk_o` stays low for the whole pulse.
- R7: `busy_o` falls exactly one clock after `rclk_o` falls.
- R8: The word is captured when the start is accepted. Later changes on `frame_i` have no effect on the frame in flight.
- R9: Over any 256 consecutive cycles with a steady duty, `oe_no` is low for exactly `duty_i` cycles. A duty of 0 keeps `oe_no` high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a refresh; taken only while idle |
| frame_i | input | FRAME_BITS | Status word, captured on an accepted start |
| duty_i | input | PWM_W | Brightness duty, in counts out of 2^PWM_W |
| sdata_o | output | 1 | Serial data to the first stage |
| sclk_o | output | 1 | Generated shift clock |
| rclk_o | output | 1 | Register (latch) clock |
| clr_no | output | 1 | Active-low clear to the chain |
| oe_no | output | 1 | Active-low output enable, PWM modulated |
| busy_o | output | 1 | High from accepted start to end of frame |

## Verification
`busy_o` is due one clock after the accepted start. The bench therefore checks it at the falling edge that follows the edge which took the strobe. Shift bits are sampled at the falling system-clock edge on which the bench first sees `sclk_o` high, which is where a downstream stage would capture them. The latch checks run at the first sample with `rclk_o` high, the busy-drop check runs exactly one sample after `rclk_o` is seen low, and phase widths are counted in samples between the transitions. PWM results lag the duty by one register, so the bench lets a new duty settle for ten cycles and then counts `oe_no` over a window of 256 cycles.

// File: rtl/sfd_pkg.sv
`timescale 1ns/1ps
package sfd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_REC,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH,
    ST_TAIL
  } seq_state_e;

endpackage

// File: rtl/sfd_phase_timer.sv
`timescale 1ns/1ps
module sfd_phase_timer #(
  parameter int HALF_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfd_dim_pwm.sv
`timescale 1ns/1ps
module sfd_dim_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PWM_W-1:0] duty_i,
  output logic             oe_no
);
  logic [PWM_W-1:0] ramp_q;
  logic             oe_q;

  assign oe_no = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      oe_q   <= 1'b1;
    end else begin
      ramp_q <= ramp_q + 1'b1;
      oe_q   <= !(ramp_q < duty_i);
    end
  end
endmodule

// File: rtl/sfd_frame_seq.sv
`timescale 1ns/1ps
module sfd_frame_seq
  import sfd_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  tick_i,
  output logic                  run_o,
  output logic                  sdata_o,
  output logic                  sclk_o,
  output logic                  rclk_o,
  output logic                  clr_no,
  output logic                  busy_o
);
  localparam int BW  = (FRAME_BITS < 2) ? 1 : $clog2(FRAME_BITS);
  localparam int MSB = FRAME_BITS - 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  seq_state_e            state_q;
  logic [FRAME_BITS-1:0] word_q;
  logic [BW-1:0]         bit_q;
  logic                  need_clr_q;
  logic                  sdata_q, sclk_q, rclk_q, clr_nq, busy_q;

  assign run_o   = (state_q != ST_IDLE) && (state_q != ST_TAIL);
  assign sdata_o = sdata_q;
  assign sclk_o  = sclk_q;
  assign rclk_o  = rclk_q;
  assign clr_no  = clr_nq;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      word_q     <= '0;
      bit_q      <= '0;
      need_clr_q <= 1'b1;
      sdata_q    <= 1'b0;
      sclk_q     <= 1'b0;
      rclk_q     <= 1'b0;
      clr_nq     <= 1'b1;
      busy_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            busy_q <= 1'b1;
            word_q <= frame_i;
            bit_q  <= '0;
            if (need_clr_q) begin
              clr_nq  <= 1'b0;
              state_q <= ST_CLR;
            end else begin
              sdata_q <= frame_i[MSB];
              state_q <= ST_LOW;
            end
          end
        end
        ST_CLR: if (tick_i) begin
          clr_nq     <= 1'b1;
          need_clr_q <= 1'b0;
          state_q    <= ST_REC;
        end
        ST_REC: if (tick_i) begin
          sdata_q <= word_q[MSB];
          state_q <= ST_LOW;
        end
        ST_LOW: if (tick_i) begin
          sclk_q  <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick_i) begin
          sclk_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            state_q <= ST_GAP;
          end else begin
            word_q  <= {word_q[MSB-1:0], 1'b0};
            sdata_q <= word_q[MSB-1];
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_GAP: if (tick_i) begin
          rclk_q  <= 1'b1;
          state_q <= ST_LATCH;
        end
        ST_LATCH: if (tick_i) begin
          rclk_q  <= 1'b0;
          state_q <= ST_TAIL;
        end
        ST_TAIL: begin
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shreg_frame_driver.sv
`timescale 1ns/1ps
module shreg_frame_driver #(
  parameter int FRAME_BITS   = 16,
  parameter int HALF_CYC     = 5,
  parameter int SYS_CLK_NS   = 10,
  parameter int MIN_PHASE_NS = 40,
  parameter int MIN_SCLK_NS  = 100,
  parameter int PWM_W        = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic [PWM_W-1:0]      duty_i,
  output logic                  sdata_o,
  output logic                  sclk_o,
  output logic                  rclk_o,
  output logic                  clr_no,
  output logic                  oe_no,
  output logic                  busy_o
);
  localparam int PHASE_NS  = HALF_CYC * SYS_CLK_NS;
  localparam int PERIOD_NS = 2 * PHASE_NS;

  if (PHASE_NS < MIN_PHASE_NS) begin : g_phase_too_short
    $error("shift phase of %0d ns is below the %0d ns minimum", PHASE_NS, MIN_PHASE_NS);
  end
  if (PERIOD_NS < MIN_SCLK_NS) begin : g_sclk_too_fast
    $error("shift period of %0d ns is below the %0d ns minimum", PERIOD_NS, MIN_SCLK_NS);
  end
  if (FRAME_BITS < 2) begin : g_frame_too_small
    $error("frame must hold at least two bits");
  end

  logic run, tick;

  sfd_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  sfd_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .frame_i(frame_i),
    .tick_i (tick),
    .run_o  (run),
    .sdata_o(sdata_o),
    .sclk_o (sclk_o),
    .rclk_o (rclk_o),
    .clr_no (clr_no),
    .busy_o (busy_o)
  );

  sfd_dim_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .duty_i(duty_i),
    .oe_no (oe_no)
  );
endmodule

// File: rtl/shreg_frame_driver_chk.sv
`timescale 1ns/1ps
module shreg_frame_driver_chk #(
  parameter int HALF_CYC = 5,
  parameter int PWM_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [PWM_W-1:0] duty_i,
  input logic             sdata_o,
  input logic             sclk_o,
  input logic             rclk_o,
  input logic             clr_no,
  input logic             oe_no,
  input logic             busy_o
);
  logic [15:0] hi_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_len_q <= '0;
    else if (sclk_o) hi_len_q <= hi_len_q + 1'b1;
    else             hi_len_q <= '0;
  end

  // R5
  sdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // R5
  sclk_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_len_q >= 16'(HALF_CYC)));

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_o && rclk_o));

  // R3
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_no |-> (!sclk_o && !rclk_o));

  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R7
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rclk_o) |=> $fell(busy_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !rclk_o && clr_no));

  // R9
  dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(duty_i) == '0) |-> oe_no);
endmodule

bind shreg_frame_driver shreg_frame_driver_chk #(
  .HALF_CYC(HALF_CYC),
  .PWM_W   (PWM_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .duty_i (duty_i),
  .sdata_o(sdata_o),
  .sclk_o (sclk_o),
  .rclk_o (rclk_o),
  .clr_no (clr_no),
  .oe_no  (oe_no),
  .busy_o (busy_o)
);

// File: tb/shreg_frame_driver_test.sv
`timescale 1ns/1ps
module shreg_frame_driver_test;
  localparam int HALF = 5;
  localparam int NB   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] frame = '0;
  logic [7:0]  duty = '0;
  logic        sdata_o, sclk_o, rclk_o, clr_no, oe_no, busy_o;

  always #5 clk = ~clk;

  shreg_frame_driver #(.HALF_CYC(HALF)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .frame_i(frame),
    .duty_i (duty),
    .sdata_o(sdata_o),
    .sclk_o (sclk_o),
    .rclk_o (rclk_o),
    .clr_no (clr_no),
    .oe_no  (oe_no),
    .busy_o (busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stage_of(input logic [15:0] w, input int idx);
    return w[idx*8 +: 8];
  endfunction

  function automatic int clr_expect(input bit first);
    return first ? HALF : 0;
  endfunction

  // expectations shared with the monitor
  logic [15:0] exp_frame = '0;
  bit          exp_clr = 1'b0;
  bit          exp_dist = 1'b0;

  // monitor state
  logic        p_sclk = 0, p_rclk = 0, p_busy = 0, p_sdata = 0;
  int          rises = 0, lo_len = 0, hi_len = 0, min_lo = 1000, min_hi = 1000;
  int          clr_len = 0, rpulses = 0, rhi_len = 0, since_rfall = 100;
  bit          sviol = 0;
  logic [7:0]  near_m = '0, far_m = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o && !p_busy) begin
        rises = 0; clr_len = 0; rpulses = 0; sviol = 0;
        min_lo = 1000; min_hi = 1000; lo_len = 0; hi_len = 0;
      end
      if (!clr_no) clr_len++;
      if (sclk_o && p_sclk && (sdata_o !== p_sdata)) sviol = 1;

      if (sclk_o && !p_sclk) begin
        if (rises > 0 && lo_len < min_lo) min_lo = lo_len;
        rises++;
        far_m  = {far_m[6:0], near_m[7]};
        near_m = {near_m[6:0], sdata_o};
        hi_len = 1;
      end else if (sclk_o) begin
        hi_len++;
      end else if (p_sclk) begin
        if (hi_len < min_hi) min_hi = hi_len;
        lo_len = 1;
      end else begin
        lo_len++;
      end

      if (rclk_o && !p_rclk) begin
        rpulses++;
        rhi_len = 1;
        check(rises == NB, "R6 latch after 16th shift edge", rises, NB);
        if (exp_dist)
          check({far_m, near_m} == exp_frame, "R8 captured word unaffected", {far_m, near_m}, exp_frame);
        check(far_m == stage_of(exp_frame, 1), "R4 far stage content", far_m, stage_of(exp_frame, 1));
        check(near_m == stage_of(exp_frame, 0), "R4 near stage content", near_m, stage_of(exp_frame, 0));
        check(!sviol, "R5 data stable while shift clock high", sviol, 0);
        check(min_hi == HALF, "R5 shift high phase width", min_hi, HALF);
        check(min_lo == HALF, "R5 shift low phase width", min_lo, HALF);
        check(clr_len == clr_expect(exp_clr), "R3 clear pulse length", clr_len, clr_expect(exp_clr));
      end else if (rclk_o) begin
        rhi_len++;
      end else if (p_rclk) begin
        check(rhi_len == HALF, "R6 latch pulse width", rhi_len, HALF);
        since_rfall = 0;
      end else begin
        since_rfall++;
      end

      if (!busy_o && p_busy) begin
        check(since_rfall == 1, "R7 busy drop after latch", since_rfall, 1);
        check(rpulses == 1, "R6 single latch pulse", rpulses, 1);
      end
    end
    p_sclk = sclk_o; p_rclk = rclk_o; p_busy = busy_o; p_sdata = sdata_o;
  end

  task automatic send(input logic [15:0] d, input bit first, input bit disturb);
    exp_frame = d; exp_clr = first; exp_dist = disturb;
    @(negedge clk);
    frame = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy_o == 1'b1, "R2 busy one clock after start", busy_o, 1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      frame = ~d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy_o == 1'b1, "R2 busy held through ignored start", busy_o, 1);
    end
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
    check(busy_o == 1'b0, "R2 frame completes", busy_o, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic pwm_window(input logic [7:0] d);
    int lows;
    lows = 0;
    @(negedge clk);
    duty = d;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (!oe_no) lows++;
      @(negedge clk);
    end
    check(lows == int'(d), "R9 enable low count", lows, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({sclk_o, rclk_o, clr_no, oe_no, busy_o, sdata_o} == 6'b001100,
          "R1 outputs in reset", {sclk_o, rclk_o, clr_no, oe_no, busy_o, sdata_o}, 6'b001100);
    rst_n = 1'b1;
    @(negedge clk);
    check({sclk_o, rclk_o, clr_no, busy_o} == 4'b0010,
          "R1 outputs after reset", {sclk_o, rclk_o, clr_no, busy_o}, 4'b0010);
  endtask

  initial begin
    void'($urandom(32'd2024));
    duty = 8'd0;
    do_reset();
    send(16'h8001, 1'b1, 1'b0);
    send(16'h0000, 1'b0, 1'b0);
    send(16'hFFFF, 1'b0, 1'b0);
    send(16'hA5C3, 1'b0, 1'b1);
    for (int k = 0; k < 12; k++) begin
      logic [15:0] r;
      r = 16'($urandom);
      send(r, 1'b0, ($urandom % 3) == 0);
    end
    pwm_window(8'd0);
    pwm_window(8'd255);
    pwm_window(8'd1);
    pwm_window(8'd128);
    for (int k = 0; k < 3; k++) pwm_window(8'($urandom));
    duty = 8'd0;
    do_reset();
    send(16'h3C5A, 1'b1, 1'b0);
    send(16'h0F0F, 1'b0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule